// File: doc/BRIEF.md
# Serial Control Port Register Slave

This block is a four-wire serial slave that lets a host read and write a small internal byte-wide register array. The wires are an active-low frame latch, a serial clock, a serial data input and a serial data output with its own output-enable, so the output can share a readback line with other slaves. All four lines are brought into a faster system clock domain through two-flop synchronisers, and their edges are found there.

After reset the port is dormant. It becomes active only after the host has pulled the latch low three times, each time for at least the minimum width. Once it is active, every frame starts with a byte that carries a 7-bit chip address and a direction bit. Two subaddress bytes follow, and then any number of data bytes. Writes land in consecutive locations. Reads return consecutive locations on the output line, which is driven only while read data is being sent. A strap input picks one of two chip addresses, so two such slaves can share one latch line.

Top module: `spi_regslave`

## Requirements
- R1: While reset is held and on its release, the port is dormant, `sdo_en` is 0 and `sdo` is 0.
- R2: The port becomes active only after the third latch low pulse that lasts at least MIN_LOW system cycles. Shorter pulses are not counted. A frame that starts while the port is dormant writes nothing and never raises `sdo_en`. Once active, the port stays active until reset.
- R3: The first byte of a frame carries the chip address in bits [7:1] and the direction in bit 0 (1 = read, 0 = write). The device address is 0 when `addr_sel` is 0 and 1 when `addr_sel` is 1. A frame whose address differs writes nothing and leaves `sdo_en` at 0.
- R4: The second and third bytes form a 16-bit subaddress, high byte first. Every byte is sent MSB first, and `sdi` is sampled on rising edges of `sclk`.
- R5: In a matching write frame, each completed data byte is stored at the current subaddress, which then advances by one. A burst of N bytes fills N consecutive locations.
- R6: A data byte that is cut short by the latch rising is discarded and does not change the array.
- R7: In a matching read frame, `sdo` changes only after falling edges of `sclk`. The MSB of the byte at the subaddress is driven after the first falling edge that follows the third byte. Each later byte comes from the next consecutive location.
- R8: `sdo_en` is 1 only during the data phase of a matching read frame in the active state. It is 0 during the three header bytes and returns to 0 within three system cycles after the latch rises.
- R9: Each location is one byte wide. Only the low log2(DEPTH) subaddress bits select a location, so addresses and burst increments wrap modulo DEPTH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, several times faster than `sclk` |
| rst | input | 1 | Synchronous active-high reset |
| addr_sel | input | 1 | Strap that selects chip address 0 or 1 |
| latch_n | input | 1 | Active-low frame latch (chip select) |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial read data to the host |
| sdo_en | output | 1 | Output enable for `sdo`; 0 means high impedance |

## Verification
A wrong header phase, bit counter or address match shows up first on `sdo_en`. It either rises during the header or during a foreign or dormant-state frame, or it stays low when read data is due. Any of these is visible within the same frame. A wrong subaddress or increment only appears at the ports when the affected location is read back, so the bench reads every written pattern and compares it byte by byte, including bursts that wrap past the top of the array. A miscounted mode-entry pulse shows up as `sdo_en` going high one frame too early, which the third dormant frame catches.

// File: rtl/spi_regslave_pkg.sv
package spi_regslave_pkg;
  localparam int SUB_W  = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    PH_CHIP,
    PH_SUBHI,
    PH_SUBLO,
    PH_DATA
  } phase_e;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int             W      = 3,
  parameter int             STAGES = 2,
  parameter logic [W-1:0]   INIT   = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) pipe[0] <= INIT;
    else     pipe[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) pipe[s] <= INIT;
      else     pipe[s] <= pipe[s-1];
    end
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/spi_mode_gate.sv
module spi_mode_gate #(
  parameter int MIN_LOW      = 2,
  parameter int ENTRY_PULSES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic latch_lvl,
  output logic spi_mode
);
  localparam int LW = $clog2(MIN_LOW + 1);
  localparam int PW = $clog2(ENTRY_PULSES + 1);

  logic [LW-1:0] low_cnt;
  logic [PW-1:0] pulse_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt   <= '0;
      pulse_cnt <= '0;
      spi_mode  <= 1'b0;
    end else if (!spi_mode) begin
      if (!latch_lvl) begin
        if (low_cnt != LW'(MIN_LOW)) low_cnt <= low_cnt + 1'b1;
      end else begin
        if (low_cnt == LW'(MIN_LOW)) begin
          pulse_cnt <= pulse_cnt + 1'b1;
          if (pulse_cnt == PW'(ENTRY_PULSES - 1)) spi_mode <= 1'b1;
        end
        low_cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/spi_regfile.sv
module spi_regfile #(
  parameter int DW    = 8,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
  import spi_regslave_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_mode,
  input  logic              addr_sel,
  input  logic              latch_lvl,
  input  logic              latch_fall,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              sdi_lvl,
  input  logic [BYTE_W-1:0] rdata,
  output logic              we,
  output logic [AW-1:0]     waddr,
  output logic [BYTE_W-1:0] wdata,
  output logic              re,
  output logic [AW-1:0]     raddr,
  output logic              sdo,
  output logic              sdo_en
);
  phase_e            phase;
  logic              active;
  logic              match;
  logic              is_read;
  logic              load_pend;
  logic [2:0]        bit_cnt;
  logic [6:0]        shreg;
  logic [SUB_W-1:0]  sub;
  logic [BYTE_W-1:0] out_byte;

  logic [BYTE_W-1:0] byte_in;
  logic [SUB_W-1:0]  sub_inc;
  logic [SUB_W-1:0]  sub_lo_val;
  logic              byte_done;

  assign byte_in    = {shreg, sdi_lvl};
  assign sub_inc    = sub + 1'b1;
  assign sub_lo_val = {sub[SUB_W-1:8], byte_in};
  assign byte_done  = sclk_rise && (bit_cnt == 3'd7);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_CHIP;
      active    <= 1'b0;
      match     <= 1'b0;
      is_read   <= 1'b0;
      load_pend <= 1'b0;
      bit_cnt   <= '0;
      shreg     <= '0;
      sub       <= '0;
      out_byte  <= '0;
      we        <= 1'b0;
      waddr     <= '0;
      wdata     <= '0;
      re        <= 1'b0;
      raddr     <= '0;
      sdo       <= 1'b0;
      sdo_en    <= 1'b0;
    end else begin
      we        <= 1'b0;
      re        <= 1'b0;
      load_pend <= re;
      if (load_pend) out_byte <= rdata;

      if (latch_fall) begin
        active  <= spi_mode;
        phase   <= PH_CHIP;
        bit_cnt <= '0;
        match   <= 1'b0;
        is_read <= 1'b0;
      end else if (latch_lvl) begin
        active <= 1'b0;
        sdo_en <= 1'b0;
      end else if (active) begin
        if (sclk_rise) begin
          bit_cnt <= bit_cnt + 1'b1;
          shreg   <= byte_in[6:0];
        end
        if (byte_done) begin
          unique case (phase)
            PH_CHIP: begin
              match   <= (byte_in[7:1] == {6'd0, addr_sel});
              is_read <= byte_in[0];
              phase   <= PH_SUBHI;
            end
            PH_SUBHI: begin
              sub[SUB_W-1:8] <= byte_in;
              phase          <= PH_SUBLO;
            end
            PH_SUBLO: begin
              sub   <= sub_lo_val;
              phase <= PH_DATA;
              if (match && is_read) begin
                re    <= 1'b1;
                raddr <= sub_lo_val[AW-1:0];
              end
            end
            PH_DATA: begin
              if (match) begin
                sub <= sub_inc;
                if (is_read) begin
                  re    <= 1'b1;
                  raddr <= sub_inc[AW-1:0];
                end else begin
                  we    <= 1'b1;
                  waddr <= sub[AW-1:0];
                  wdata <= byte_in;
                end
              end
            end
            default: phase <= PH_CHIP;
          endcase
        end
        if (sclk_fall && phase == PH_DATA && match && is_read) begin
          sdo_en <= 1'b1;
          sdo    <= out_byte[~bit_cnt];
        end
      end
    end
  end
endmodule

// File: rtl/spi_regslave.sv
module spi_regslave
  import spi_regslave_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int MIN_LOW      = 2,
  parameter int ENTRY_PULSES = 3,
  parameter int DEPTH        = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic addr_sel,
  input  logic latch_n,
  input  logic sclk,
  input  logic sdi,
  output logic sdo,
  output logic sdo_en
);
  localparam int AW = $clog2(DEPTH);

  logic [2:0]        sync_out;
  logic              latch_s, sclk_s, sdi_s;
  logic              latch_q, sclk_q;
  logic              latch_fall, sclk_rise, sclk_fall;
  logic              spi_mode;
  logic              reg_we, reg_re;
  logic [AW-1:0]     reg_waddr, reg_raddr;
  logic [BYTE_W-1:0] reg_wdata, reg_rdata;

  spi_sync #(.W(3), .STAGES(SYNC_STAGES), .INIT(3'b100)) u_sync (
    .clk (clk),
    .rst (rst),
    .din ({latch_n, sclk, sdi}),
    .dout(sync_out)
  );

  assign {latch_s, sclk_s, sdi_s} = sync_out;

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= 1'b1;
      sclk_q  <= 1'b0;
    end else begin
      latch_q <= latch_s;
      sclk_q  <= sclk_s;
    end
  end

  assign latch_fall = latch_q & ~latch_s;
  assign sclk_rise  = ~sclk_q & sclk_s;
  assign sclk_fall  = sclk_q & ~sclk_s;

  spi_mode_gate #(.MIN_LOW(MIN_LOW), .ENTRY_PULSES(ENTRY_PULSES)) u_gate (
    .clk      (clk),
    .rst      (rst),
    .latch_lvl(latch_s),
    .spi_mode (spi_mode)
  );

  spi_frame_engine #(.AW(AW)) u_engine (
    .clk       (clk),
    .rst       (rst),
    .spi_mode  (spi_mode),
    .addr_sel  (addr_sel),
    .latch_lvl (latch_s),
    .latch_fall(latch_fall),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .sdi_lvl   (sdi_s),
    .rdata     (reg_rdata),
    .we        (reg_we),
    .waddr     (reg_waddr),
    .wdata     (reg_wdata),
    .re        (reg_re),
    .raddr     (reg_raddr),
    .sdo       (sdo),
    .sdo_en    (sdo_en)
  );

  spi_regfile #(.DW(BYTE_W), .DEPTH(DEPTH)) u_mem (
    .clk  (clk),
    .we   (reg_we),
    .waddr(reg_waddr),
    .wdata(reg_wdata),
    .re   (reg_re),
    .raddr(reg_raddr),
    .rdata(reg_rdata)
  );
endmodule

// File: rtl/spi_regslave_chk.sv
module spi_regslave_chk (
  input logic clk,
  input logic rst,
  input logic spi_mode,
  input logic latch_s,
  input logic sclk_fall,
  input logic sdo,
  input logic sdo_en,
  input logic reg_we
);
  // R2
  mode_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    spi_mode |=> spi_mode);

  // R2
  no_write_dormant_chk: assert property (@(posedge clk) disable iff (rst)
    reg_we |-> spi_mode);

  // R8
  en_needs_mode_chk: assert property (@(posedge clk) disable iff (rst)
    sdo_en |-> spi_mode);

  // R8
  en_drop_chk: assert property (@(posedge clk) disable iff (rst)
    latch_s |=> !sdo_en);

  // R7
  sdo_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !sclk_fall |=> $stable(sdo));

  // R5
  we_single_chk: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> !reg_we);
endmodule

bind spi_regslave spi_regslave_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .spi_mode (spi_mode),
  .latch_s  (latch_s),
  .sclk_fall(sclk_fall),
  .sdo      (sdo),
  .sdo_en   (sdo_en),
  .reg_we   (reg_we)
);

// File: tb/spi_regslave_bench.sv
module spi_regslave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8 * CLK_PERIOD;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic addr_sel = 1'b0;
  logic latch_n = 1'b1;
  logic sclk = 1'b0;
  logic sdi = 1'b0;
  logic sdo, sdo_en;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [7:0] wdat [16];
  logic [7:0] rcap [16];
  logic       oe_hdr, oe_dat;

  logic [7:0] exp_q [$];
  logic [7:0] act_q [$];
  string      tag_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_regslave u_spi_regslave (
    .clk(clk), .rst(rst), .addr_sel(addr_sel), .latch_n(latch_n),
    .sclk(sclk), .sdi(sdi), .sdo(sdo), .sdo_en(sdo_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, input int nbits, output logic [7:0] rx,
                      inout logic oe_seen);
    rx = '0;
    for (int i = 7; i > 7 - nbits; i--) begin
      sclk = 1'b0;
      sdi  = tx[i];
      #HALF;
      sclk = 1'b1;
      #HALF;
      rx[i]   = sdo;
      oe_seen = oe_seen | sdo_en;
    end
  endtask

  task automatic frame(input logic [7:0] chip, input logic [15:0] sub,
                       input int nbytes, input int tail_bits);
    logic [7:0] dummy;
    oe_hdr = 1'b0;
    oe_dat = 1'b0;
    latch_n = 1'b0;
    #HALF;
    xfer(chip, 8, dummy, oe_hdr);
    xfer(sub[15:8], 8, dummy, oe_hdr);
    xfer(sub[7:0], 8, dummy, oe_hdr);
    for (int b = 0; b < nbytes; b++) xfer(wdat[b], 8, rcap[b], oe_dat);
    if (tail_bits > 0) xfer(wdat[nbytes], tail_bits, dummy, oe_dat);
    sclk = 1'b0;
    #HALF;
    latch_n = 1'b1;
    #(4 * HALF);
  endtask

  task automatic wr(input logic [7:0] chip, input logic [15:0] sub, input int n);
    frame(chip, sub, n, 0);
  endtask

  // Driver: pushes expected bytes, runs the read, hands captured bytes to the monitor.
  task automatic rd_expect(input string req, input logic [7:0] chip, input logic [15:0] sub,
                           input int n, input logic [7:0] e0, input logic [7:0] e1,
                           input logic [7:0] e2, input logic [7:0] e3);
    logic [7:0] ev [4];
    ev = '{e0, e1, e2, e3};
    for (int b = 0; b < n; b++) begin
      exp_q.push_back(ev[b]);
      tag_q.push_back(req);
    end
    frame(chip, sub, n, 0);
    chk({req, " R8 sdo_en low in header"}, 32'(oe_hdr), 0);
    chk({req, " R8 sdo_en high in data"}, 32'(oe_dat), 1);
    chk({req, " R8 sdo_en low after latch"}, 32'(sdo_en), 0);
    for (int b = 0; b < n; b++) act_q.push_back(rcap[b]);
  endtask

  // Monitor: pops and compares as captured bytes arrive.
  initial begin
    forever begin
      @(negedge clk);
      while (act_q.size() > 0 && exp_q.size() > 0) begin
        automatic logic [7:0] a = act_q.pop_front();
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk({t, " read byte"}, 32'(a), 32'(e));
      end
    end
  end

  task automatic pulse(input int cycles);
    latch_n = 1'b0;
    #(cycles * CLK_PERIOD);
    latch_n = 1'b1;
    #(5 * CLK_PERIOD);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    #(4 * CLK_PERIOD);
    // R1: reset state
    chk("R1 sdo_en in reset", 32'(sdo_en), 0);
    chk("R1 sdo in reset", 32'(sdo), 0);
    rst = 1'b0;
    #(3 * CLK_PERIOD);
    chk("R1 sdo_en after reset", 32'(sdo_en), 0);

    // R2: one valid pulse, one glitch, then two dormant read frames
    pulse(5);
    pulse(1);
    frame(8'h01, 16'h0000, 1, 0);
    chk("R2 dormant frame 2 no drive", 32'(oe_hdr | oe_dat), 0);
    frame(8'h01, 16'h0000, 1, 0);
    chk("R2 glitch not counted, frame 3 no drive", 32'(oe_hdr | oe_dat), 0);
    frame(8'h01, 16'h0000, 1, 0);
    chk("R2 active after three pulses", 32'(oe_dat), 1);
    chk("R8 header undriven", 32'(oe_hdr), 0);

    // R5 R7 R4: single write and readback
    wdat[0] = 8'hA5;
    wr(8'h00, 16'h0005, 1);
    rd_expect("R5 R7 single", 8'h01, 16'h0005, 1, 8'hA5, 0, 0, 0);

    // R5 R7: burst
    wdat[0] = 8'h11; wdat[1] = 8'h22; wdat[2] = 8'h33; wdat[3] = 8'h44;
    wr(8'h00, 16'h0010, 4);
    rd_expect("R5 R7 burst", 8'h01, 16'h0010, 4, 8'h11, 8'h22, 8'h33, 8'h44);
    rd_expect("R7 burst offset", 8'h01, 16'h0012, 2, 8'h33, 8'h44, 0, 0);

    // R4 R9: high subaddress bits ignored; byte order matters
    wdat[0] = 8'h3C;
    wr(8'h00, 16'h0143, 1);
    rd_expect("R4 R9 alias", 8'h01, 16'h0003, 1, 8'h3C, 0, 0, 0);
    wdat[0] = 8'h66;
    wr(8'h00, 16'h0000, 1);
    wdat[0] = 8'h77;
    wr(8'h00, 16'h003F, 1);
    rd_expect("R9 burst wrap", 8'h01, 16'h003F, 2, 8'h77, 8'h66, 0, 0);

    // R6: partial trailing byte discarded
    wdat[0] = 8'h12;
    wr(8'h00, 16'h0021, 1);
    wdat[0] = 8'h5E; wdat[1] = 8'hFF;
    frame(8'h00, 16'h0020, 1, 5);
    rd_expect("R6 partial byte", 8'h01, 16'h0020, 2, 8'h5E, 8'h12, 0, 0);

    // R3: foreign address ignored
    wdat[0] = 8'h00;
    wr(8'h02, 16'h0005, 1);
    frame(8'h03, 16'h0005, 1, 0);
    chk("R3 foreign read undriven", 32'(oe_hdr | oe_dat), 0);
    rd_expect("R3 foreign write ignored", 8'h01, 16'h0005, 1, 8'hA5, 0, 0, 0);

    // R3: strap selects address 1
    addr_sel = 1'b1;
    #(4 * CLK_PERIOD);
    wdat[0] = 8'hC3;
    wr(8'h02, 16'h0005, 1);
    rd_expect("R3 strap high", 8'h03, 16'h0005, 1, 8'hC3, 0, 0, 0);
    frame(8'h01, 16'h0005, 1, 0);
    chk("R3 old address now foreign", 32'(oe_hdr | oe_dat), 0);

    #(20 * CLK_PERIOD);
    chk("R7 scoreboard drained", 32'(exp_q.size()), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule